// File: doc/BRIEF.md
# Two-Queue Mailbox Controller with Channel Routing

This block links a 32-bit register bus to a set of numbered service channels. It holds two message queues. The inbound queue carries responses toward the host. The outbound queue holds host requests that could not be delivered yet.

When the host writes a message word, the low nibble of that word names the target channel. If the target channel is idle, the word goes straight to it. If the channel reports pending work, the word is parked in the outbound queue. Parked words are not retried.

Channel responses are collected automatically, at most one word per clock, always from the lowest-numbered channel that has one ready. Collection stops while the inbound queue is full. The host reads responses back through a popping window or a non-popping head view. It can arm a single interrupt line that is raised while responses wait.

The bus port carries only the 8-bit offset inside the block's window. A register access acts only when all four byte lanes are enabled. Read data is registered and appears on the cycle after the read is presented.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset the configuration reads zero, both status words read 0x4000_0000 (empty), and no request strobe, acknowledge or interrupt is active. While reset is held no channel word is acknowledged.
- R2: An access with byte enables other than 4'hF has no effect: it pops nothing, changes no configuration and delivers no message. Reads at offset 0x94, at unaligned offsets and at any unlisted offset return zero.
- R3: A read at 0x80, 0x84, 0x88 or 0x8C returns the inbound head and removes it. When the inbound queue is empty it returns the marker 0xFFFF_FFFF and removes nothing.
- R4: A read at 0x90 returns the inbound head without removing it, or 0xFFFF_FFFF when the queue is empty.
- R5: Status words use bit 31 for full and bit 30 for empty; all other bits read zero. Offset 0x98 gives the inbound status and 0xB8 gives the outbound status.
- R6: A write at 0x9C updates only configuration bit 0 (interrupt enable). Configuration bit 4 reads 1 exactly when the inbound queue holds a word. The interrupt output equals bit 0 AND bit 4.
- R7: Writes at 0xA0, 0xA4, 0xA8 or 0xAC select a channel with data bits [3:0]. Such a write is dropped when the channel number is at or above the channel count, or when the outbound queue is full.
- R8: For a write that is not dropped: if the selected channel's pending input is high, the word enters the outbound queue. Otherwise that channel's request strobe is high for exactly the next cycle, with the whole word on the request data bus.
- R9: Each cycle in which the inbound queue is not full, the lowest-numbered channel with its available input high gets a one-cycle acknowledge, and its word is appended to the inbound queue. Words from one channel keep their order. When the queue becomes full, collection stops; it resumes after a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the window |
| bus_be | input | 4 | Byte enables; only 4'hF acts |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| chan_avail | input | NCH | Channel has a response word ready |
| chan_rsp_data | input | NCH*32 | Response words, channel c at bits [32c+31:32c] |
| chan_ack | output | NCH | One-cycle take strobe per channel |
| chan_pend | input | NCH | Channel busy; requests to it are parked |
| req_valid | output | NCH | One-cycle request strobe per channel |
| req_data | output | 32 | Request word |
| irq | output | 1 | Host interrupt |

## Verification
The bench keeps the default of nine channels, so channel numbers 9 to 15 fall on the rejected side of the range check while channel 8 stays valid. Both queues are built four deep. At that depth, filling the inbound queue from one channel holding six words reaches the full stop and the refill after each pop within a few cycles, and four parked writes fill the outbound queue so that the full-drop path can be exercised.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CHSEL_W  = 4;
  localparam logic [WORD_W-1:0] NO_DATA = 32'hFFFF_FFFF;
  localparam int unsigned ST_FULL_BIT  = 31;
  localparam int unsigned ST_EMPTY_BIT = 30;
  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned CFG_PEND_BIT = 4;

  typedef enum logic [2:0] {
    RS_NONE, RS_POP, RS_PEEK, RS_IN_ST, RS_CFG, RS_OUT_ST
  } rsel_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32,
  parameter logic [DW-1:0] EMPTY_WORD = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? EMPTY_WORD : mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/mbx_route.sv
module mbx_route
  import mbx_pkg::*;
#(
  parameter int unsigned NCH = 9
) (
  input  logic              wr_fire,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ob_full,
  input  logic [NCH-1:0]    chan_pend,
  output logic              park,
  output logic [NCH-1:0]    send
);
  logic [NCH-1:0] hit;
  logic           busy, ok;

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign hit[c] = (wr_data[CHSEL_W-1:0] == CHSEL_W'(c));
  end

  assign busy = |(hit & chan_pend);
  assign ok   = wr_fire && !ob_full && (|hit);
  assign park = ok && busy;
  assign send = (ok && !busy) ? hit : '0;
endmodule

// File: rtl/mbx_drain.sv
module mbx_drain
  import mbx_pkg::*;
#(
  parameter int unsigned NCH = 9
) (
  input  logic                  enable,
  input  logic [NCH-1:0]        chan_avail,
  input  logic [NCH*WORD_W-1:0] chan_rsp_data,
  output logic [NCH-1:0]        chan_ack,
  output logic                  take,
  output logic [WORD_W-1:0]     take_data
);
  always_comb begin
    chan_ack  = '0;
    take_data = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (chan_avail[c]) begin
        chan_ack  = '0;
        chan_ack[c] = enable;
        take_data = chan_rsp_data[c*WORD_W +: WORD_W];
      end
    end
  end

  assign take = |chan_ack;
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned NCH      = 9,
  parameter int unsigned IN_DEPTH = 8,
  parameter int unsigned OB_DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [7:0]            bus_addr,
  input  logic [3:0]            bus_be,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  input  logic [NCH-1:0]        chan_avail,
  input  logic [NCH*WORD_W-1:0] chan_rsp_data,
  output logic [NCH-1:0]        chan_ack,
  input  logic [NCH-1:0]        chan_pend,
  output logic [NCH-1:0]        req_valid,
  output logic [WORD_W-1:0]     req_data,
  output logic                  irq
);
  logic rs_q1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rst_s <= rs_q1;
    end
  end

  logic acc, rd_acc, wr_acc, aligned;
  logic [3:0] off_hi;
  assign acc     = bus_sel && (bus_be == 4'hF);
  assign rd_acc  = acc && !bus_we;
  assign wr_acc  = acc && bus_we;
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign off_hi  = bus_addr[7:4];

  rsel_e rsel;
  always_comb begin
    rsel = RS_NONE;
    if (aligned) begin
      if (off_hi == 4'h8)           rsel = RS_POP;
      else if (bus_addr == 8'h90)   rsel = RS_PEEK;
      else if (bus_addr == 8'h98)   rsel = RS_IN_ST;
      else if (bus_addr == 8'h9C)   rsel = RS_CFG;
      else if (bus_addr == 8'hB8)   rsel = RS_OUT_ST;
    end
  end

  logic cfg_wr, msg_wr;
  assign cfg_wr = wr_acc && (bus_addr == 8'h9C);
  assign msg_wr = wr_acc && aligned && (off_hi == 4'hA);

  logic              in_empty, in_full, in_pop, in_push;
  logic [WORD_W-1:0] in_head, in_wdata;
  logic              ob_empty, ob_full, ob_push;
  logic [WORD_W-1:0] ob_head;
  logic [NCH-1:0]    send;

  assign in_pop = rd_acc && (rsel == RS_POP);

  mbx_drain #(.NCH(NCH)) u_drain (
    .enable        (rst_s && !in_full),
    .chan_avail    (chan_avail),
    .chan_rsp_data (chan_rsp_data),
    .chan_ack      (chan_ack),
    .take          (in_push),
    .take_data     (in_wdata)
  );

  mbx_fifo #(.DEPTH(IN_DEPTH), .DW(WORD_W), .EMPTY_WORD(NO_DATA)) u_inq (
    .clk       (clk),
    .rst_n     (rst_s),
    .push      (in_push),
    .push_data (in_wdata),
    .pop       (in_pop),
    .head      (in_head),
    .empty     (in_empty),
    .full      (in_full)
  );

  mbx_route #(.NCH(NCH)) u_route (
    .wr_fire   (msg_wr),
    .wr_data   (bus_wdata),
    .ob_full   (ob_full),
    .chan_pend (chan_pend),
    .park      (ob_push),
    .send      (send)
  );

  mbx_fifo #(.DEPTH(OB_DEPTH), .DW(WORD_W), .EMPTY_WORD(NO_DATA)) u_obq (
    .clk       (clk),
    .rst_n     (rst_s),
    .push      (ob_push),
    .push_data (bus_wdata),
    .pop       (1'b0),
    .head      (ob_head),
    .empty     (ob_empty),
    .full      (ob_full)
  );

  logic cfg_en_q, cfg_en_d;
  logic [WORD_W-1:0] cfg_word, in_status, ob_status, rdata_d;
  logic [NCH-1:0]    req_valid_d;
  logic [WORD_W-1:0] req_data_d;

  always_comb begin
    cfg_en_d = cfg_wr ? bus_wdata[CFG_EN_BIT] : cfg_en_q;

    cfg_word = '0;
    cfg_word[CFG_EN_BIT]   = cfg_en_q;
    cfg_word[CFG_PEND_BIT] = !in_empty;

    in_status = '0;
    in_status[ST_FULL_BIT]  = in_full;
    in_status[ST_EMPTY_BIT] = in_empty;
    ob_status = '0;
    ob_status[ST_FULL_BIT]  = ob_full;
    ob_status[ST_EMPTY_BIT] = ob_empty;

    unique case (rsel)
      RS_POP, RS_PEEK: rdata_d = in_head;
      RS_IN_ST:        rdata_d = in_status;
      RS_CFG:          rdata_d = cfg_word;
      RS_OUT_ST:       rdata_d = ob_status;
      default:         rdata_d = '0;
    endcase

    req_valid_d = send;
    req_data_d  = (|send) ? bus_wdata : req_data;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cfg_en_q  <= 1'b0;
      bus_rdata <= '0;
      req_valid <= '0;
      req_data  <= '0;
    end else begin
      cfg_en_q  <= cfg_en_d;
      req_valid <= req_valid_d;
      req_data  <= req_data_d;
      if (rd_acc) bus_rdata <= rdata_d;
    end
  end

  assign irq = cfg_word[CFG_EN_BIT] & cfg_word[CFG_PEND_BIT];
endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk
  import mbx_pkg::*;
#(
  parameter int unsigned NCH = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    chan_avail,
  input logic [NCH-1:0]    chan_ack,
  input logic [NCH-1:0]    chan_pend,
  input logic [NCH-1:0]    req_valid,
  input logic              irq,
  input logic              in_empty,
  input logic              in_full,
  input logic              ob_empty,
  input logic [WORD_W-1:0] ob_head
);
  AST_ACK_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_ack)); // R9
  AST_ACK_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_ack != '0) |-> ((chan_avail & (chan_ack - NCH'(1))) == '0)); // R9
  AST_ACK_ONLY_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_ack & ~chan_avail) == '0)); // R9
  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    in_full |-> (chan_ack == '0)); // R9
  AST_REQ_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_valid)); // R8
  AST_REQ_NOT_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid != '0) |-> (($past(chan_pend) & req_valid) == '0)); // R8
  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !in_empty); // R6
  AST_OB_EMPTY_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    ob_empty |-> (ob_head == NO_DATA)); // R3
endmodule

bind mbx_ctrl mbx_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s),
  .chan_avail (chan_avail),
  .chan_ack   (chan_ack),
  .chan_pend  (chan_pend),
  .req_valid  (req_valid),
  .irq        (irq),
  .in_empty   (in_empty),
  .in_full    (in_full),
  .ob_empty   (ob_empty),
  .ob_head    (ob_head)
);

// File: tb/tb_mbx_ctrl.sv
`timescale 1ns/1ps
module tb_mbx_ctrl;
  localparam int NCH = 9;
  localparam int DEP = 4;
  localparam logic [31:0] MARK = 32'hFFFF_FFFF;
  localparam logic [31:0] ST_E = 32'h4000_0000;
  localparam logic [31:0] ST_F = 32'h8000_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic            bus_sel, bus_we;
  logic [7:0]      bus_addr;
  logic [3:0]      bus_be;
  logic [31:0]     bus_wdata, bus_rdata;
  logic [NCH-1:0]  chan_avail, chan_ack, chan_pend, req_valid;
  logic [NCH*32-1:0] chan_rsp_data;
  logic [31:0]     req_data;
  logic            irq;

  mbx_ctrl #(.NCH(NCH), .IN_DEPTH(DEP), .OB_DEPTH(DEP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .chan_avail(chan_avail),
    .chan_rsp_data(chan_rsp_data), .chan_ack(chan_ack),
    .chan_pend(chan_pend), .req_valid(req_valid), .req_data(req_data),
    .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  // channel response model: words queued per channel, advanced on ack
  logic [31:0]    rsp_mem [NCH][8];
  int             rsp_wr [NCH];
  int             rsp_rd [NCH];
  logic [NCH-1:0] ack_seen;

  initial begin
    ack_seen = '0;
    for (int c = 0; c < NCH; c++) begin
      rsp_wr[c] = 0;
      rsp_rd[c] = 0;
    end
  end

  always begin
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (ack_seen[c]) rsp_rd[c] = rsp_rd[c] + 1;
      chan_avail[c] = (rsp_rd[c] < rsp_wr[c]);
      chan_rsp_data[c*32 +: 32] = rsp_mem[c][rsp_rd[c] % 8];
    end
    #1 ack_seen = chan_ack;
  end

  task automatic load(input int c, input logic [31:0] w);
    rsp_mem[c][rsp_wr[c] % 8] = w;
    rsp_wr[c] = rsp_wr[c] + 1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d,
                        input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    check("R1", "irq", {31'b0, irq}, 32'h0);
    check("R1", "req_valid", {23'b0, req_valid}, 32'h0);
    bus_rd(8'h98, d); check("R1", "in status", d, ST_E);
    bus_rd(8'hB8, d); check("R1", "out status", d, ST_E);
    bus_rd(8'h9C, d); check("R1", "config", d, 32'h0);
    bus_rd(8'h84, d); check("R3", "pop empty", d, MARK);
    bus_rd(8'h90, d); check("R4", "peek empty", d, MARK);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    bus_rd(8'h94, d); check("R2", "read 0x94", d, 32'h0);
    bus_rd(8'h00, d); check("R2", "read 0x00", d, 32'h0);
    bus_rd(8'h9A, d); check("R2", "unaligned 0x9A", d, 32'h0);
    bus_wr(8'h9C, 32'hFFFF_FFFF, 4'h1);
    bus_rd(8'h9C, d); check("R2", "partial cfg write ignored", d, 32'h0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    bus_wr(8'h9C, 32'hFFFF_FFFE);
    bus_rd(8'h9C, d); check("R6", "cfg bit0 clear write", d, 32'h0);
    bus_wr(8'h9C, 32'h0000_0001);
    bus_rd(8'h9C, d); check("R6", "cfg enable, empty", d, 32'h1);
    check("R6", "irq empty", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_drain_order();
    logic [31:0] d;
    load(5, 32'hA5A5_0005);
    load(2, 32'hB0B0_0002);
    load(2, 32'hC0C0_0002);
    idle(6);
    check("R6", "irq with data", {31'b0, irq}, 32'h1);
    bus_rd(8'h9C, d); check("R6", "cfg pending", d, 32'h11);
    bus_rd(8'h90, d); check("R4", "peek", d, 32'hB0B0_0002);
    bus_rd(8'h90, d); check("R4", "peek keeps", d, 32'hB0B0_0002);
    bus_rd(8'h80, d, 4'h3);
    bus_rd(8'h90, d); check("R2", "partial read no pop", d, 32'hB0B0_0002);
    bus_rd(8'h80, d); check("R9", "first lowest ch", d, 32'hB0B0_0002);
    bus_rd(8'h8C, d); check("R9", "same ch order", d, 32'hC0C0_0002);
    bus_rd(8'h88, d); check("R9", "higher ch last", d, 32'hA5A5_0005);
    bus_rd(8'h80, d); check("R3", "drained empty", d, MARK);
    check("R6", "irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int i = 0; i < 6; i++) load(0, 32'h0D00_0000 + i);
    idle(8);
    bus_rd(8'h98, d); check("R5", "in full status", d, ST_F);
    check("R9", "words left at channel", rsp_wr[0] - rsp_rd[0], 32'd2);
    for (int i = 0; i < 6; i++) begin
      bus_rd(8'h84, d); check("R9", "full refill order", d, 32'h0D00_0000 + i);
    end
    bus_rd(8'h84, d); check("R3", "after full drain", d, MARK);
    bus_rd(8'h98, d); check("R5", "in empty again", d, ST_E);
  endtask

  task automatic t_route();
    logic [31:0] d;
    chan_pend = '0;
    bus_wr(8'hA4, 32'h1234_5673);
    check("R8", "req strobe ch3", {23'b0, req_valid}, 32'h8);
    check("R8", "req data", req_data, 32'h1234_5673);
    @(negedge clk);
    check("R8", "strobe one cycle", {23'b0, req_valid}, 32'h0);
    bus_wr(8'hA0, 32'hABCD_000C);
    check("R7", "ch12 no strobe", {23'b0, req_valid}, 32'h0);
    bus_rd(8'hB8, d); check("R7", "ch12 not parked", d, ST_E);
    bus_wr(8'hA8, 32'h0000_0108);
    check("R7", "ch8 valid", {23'b0, req_valid}, 32'h100);
    chan_pend[6] = 1'b1;
    bus_wr(8'hAC, 32'h5555_0006);
    check("R8", "busy no strobe", {23'b0, req_valid}, 32'h0);
    bus_rd(8'hB8, d); check("R5", "out partly filled", d, 32'h0);
    for (int i = 1; i < DEP; i++) bus_wr(8'hA0, 32'h5555_0006 + (i << 8));
    bus_rd(8'hB8, d); check("R5", "out full", d, ST_F);
    chan_pend[6] = 1'b0;
    bus_wr(8'hA0, 32'h0000_0011);
    check("R7", "out full drops", {23'b0, req_valid}, 32'h0);
  endtask

  task automatic t_reset_hold();
    logic [31:0] d;
    @(negedge clk);
    rst_n = 1'b0;
    load(8, 32'h8888_0008);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1 check("R1", "no ack in reset", {23'b0, chan_ack}, 32'h0);
    end
    rst_n = 1'b1;
    idle(5);
    bus_rd(8'hB8, d); check("R1", "out cleared", d, ST_E);
    bus_rd(8'h9C, d); check("R1", "cfg cleared, pending", d, 32'h10);
    check("R6", "irq off after reset", {31'b0, irq}, 32'h0);
    bus_rd(8'h80, d); check("R9", "post-reset drain", d, 32'h8888_0008);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0;
    bus_wdata = '0; chan_pend = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset_state();
    t_decode();
    t_config();
    t_drain_order();
    t_full();
    t_route();
    t_reset_hold();
    finish_sim();
  end
endmodule